// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the arithmetic and logic stage of a small accumulator machine. It takes the accumulator value and a second operand from the buffer register. A 4-bit function code selects one of eight operations. The result is 16 bits wide and is meant to be written back into the accumulator by the surrounding datapath.

The block has no state and no clock. Its result, a flag saying whether the function code is a recognised one, and a flag saying whether the accumulator holds a strictly positive signed value all follow the inputs combinationally. The sequencer reads the positive flag to decide the conditional jump. Arithmetic wraps modulo 2^16, the product keeps only its low half, and there is no carry or overflow output.

Top module: `acc_alu`

## Requirements
- R1: With function code 4'h3, the result is (accumulator + operand) mod 2^16.
- R2: With function code 4'h4, the result is (accumulator - operand) mod 2^16.
- R3: With function code 4'h6, the result is the bitwise AND of accumulator and operand.
- R4: With function code 4'h7, the result is the bitwise OR of accumulator and operand.
- R5: With function code 4'h8, the result is the bitwise inverse of the accumulator, and the operand has no effect on it.
- R6: With function code 4'h9, the result is the accumulator shifted right by one bit, with bit 15 of the result equal to 0.
- R7: With function code 4'hA, the result is the accumulator shifted left by one bit, with bit 0 of the result equal to 0.
- R8: With function code 4'hB, the result is the low 16 bits of the unsigned product of accumulator and operand.
- R9: With any other function code (0, 1, 2, 5, C, D, E, F), the result equals the accumulator and the valid flag is 0.
- R10: The valid flag is 1 exactly for the codes 3, 4, 6, 7, 8, 9, A and B.
- R11: The positive flag is 1 exactly when bit 15 of the accumulator is 0 and the accumulator is not zero. It does not depend on the code or the operand.
- R12: All outputs follow the inputs with no clock, so a changed input is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 16 | Accumulator value, first operand |
| opnd_i | input | 16 | Buffer register value, second operand |
| func_i | input | 4 | Function code |
| res_o | output | 16 | Operation result |
| valid_o | output | 1 | Function code is recognised |
| pos_o | output | 1 | Accumulator is strictly positive as a signed number |

## Verification
Every one of the 16 function codes is applied to a grid of edge values: 0, 1, the largest positive value, the most negative value, all ones, and two alternating bit patterns. This grid separates carry and borrow wraparound, shift fill at both ends, and the sign and zero boundary of the positive flag. A long pseudo-random sweep then exercises the product truncation and the adder on dense values. Under the inverse code the operand is varied while the accumulator is held, which shows that the operand is ignored. The unlisted codes are mixed through both sweeps to tell a pass-through from a computed result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        FN_ADD = 4'h3,
        FN_SUB = 4'h4,
        FN_AND = 4'h6,
        FN_OR  = 4'h7,
        FN_INV = 4'h8,
        FN_SHR = 4'h9,
        FN_SHL = 4'hA,
        FN_MUL = 4'hB
    } alu_fn_e;

    function automatic logic fn_known(input logic [3:0] code);
        case (code)
            FN_ADD, FN_SUB, FN_AND, FN_OR,
            FN_INV, FN_SHR, FN_SHL, FN_MUL: fn_known = 1'b1;
            default:                        fn_known = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        sum_o = full[W-1:0];
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] inv_o,
    output logic [W-1:0] shr_o,
    output logic [W-1:0] shl_o
);
    always_comb begin
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
        inv_o = ~a_i;
        shr_o = {1'b0, a_i[W-1:1]};
        shl_o = {a_i[W-2:0], 1'b0};
    end
endmodule

// File: rtl/acc_alu_mul.sv
module acc_alu_mul #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prod_o
);
    logic [W-1:0] part [W+1];

    assign part[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_row
        logic [W-1:0] term;
        assign term      = b_i[i] ? (a_i << i) : '0;
        assign part[i+1] = part[i] + term;
    end

    assign prod_o = part[W];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic [3:0]   func_i,
    output logic [W-1:0] res_o,
    output logic         valid_o,
    output logic         pos_o
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         valid;
        logic         pos;
    } out_t;

    logic [W-1:0] sum_w, and_w, or_w, inv_w, shr_w, shl_w, prod_w;
    out_t         out_d;

    acc_alu_addsub #(.W(W)) u_addsub (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .sub_i (func_i == FN_SUB),
        .sum_o (sum_w)
    );

    acc_alu_logic #(.W(W)) u_logic (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .and_o (and_w),
        .or_o  (or_w),
        .inv_o (inv_w),
        .shr_o (shr_w),
        .shl_o (shl_w)
    );

    acc_alu_mul #(.W(W)) u_mul (
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .prod_o (prod_w)
    );

    always_comb begin
        out_d       = '0;
        out_d.valid = fn_known(func_i);
        out_d.pos   = ~acc_i[W-1] & (|acc_i);
        case (func_i)
            FN_ADD, FN_SUB: out_d.res = sum_w;
            FN_AND:         out_d.res = and_w;
            FN_OR:          out_d.res = or_w;
            FN_INV:         out_d.res = inv_w;
            FN_SHR:         out_d.res = shr_w;
            FN_SHL:         out_d.res = shl_w;
            FN_MUL:         out_d.res = prod_w;
            default:        out_d.res = acc_i;
        endcase
    end

    assign res_o   = out_d.res;
    assign valid_o = out_d.valid;
    assign pos_o   = out_d.pos;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] acc_i,
    input logic [W-1:0] opnd_i,
    input logic [3:0]   func_i,
    input logic [W-1:0] res_o,
    input logic         valid_o,
    input logic         pos_o
);
    logic [W-1:0] back_w;
    assign back_w = res_o + opnd_i;

    always_comb begin
        // R2
        sub_inverse_chk: assert (!(func_i == 4'h4) || back_w == acc_i);
        // R5
        inv_cancel_chk: assert (!(func_i == 4'h8) || (res_o ^ acc_i) == {W{1'b1}});
        // R6
        shr_fill_chk: assert (!(func_i == 4'h9) || res_o[W-1] == 1'b0);
        // R7
        shl_fill_chk: assert (!(func_i == 4'hA) || res_o[0] == 1'b0);
        // R9
        pass_chk: assert (valid_o || res_o == acc_i);
        // R11
        pos_sign_chk: assert (!pos_o || (!acc_i[W-1] && acc_i != '0));
        // R3
        and_subset_chk: assert (!(func_i == 4'h6) || (res_o & ~acc_i) == '0);
    end
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .func_i  (func_i),
    .res_o   (res_o),
    .valid_o (valid_o),
    .pos_o   (pos_o)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] acc, opnd;
    logic [3:0]  func;
    logic [15:0] res;
    logic        valid, pos;
    int          checks = 0;
    int          fails = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    acc_alu dut (
        .acc_i   (acc),
        .opnd_i  (opnd),
        .func_i  (func),
        .res_o   (res),
        .valid_o (valid),
        .pos_o   (pos)
    );

    function automatic string tag(input logic [3:0] f);
        case (f)
            4'h3: tag = "R1";
            4'h4: tag = "R2";
            4'h6: tag = "R3";
            4'h7: tag = "R4";
            4'h8: tag = "R5";
            4'h9: tag = "R6";
            4'hA: tag = "R7";
            4'hB: tag = "R8";
            default: tag = "R9";
        endcase
    endfunction

    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [3:0] f);
        logic [31:0] p;
        logic [15:0] e_res;
        logic        e_val, e_pos;
        @(posedge clk);
        acc = a; opnd = b; func = f;
        #1;
        p     = 32'(a) * 32'(b);
        e_val = 1'b1;
        case (f)
            4'h3: e_res = a + b;
            4'h4: e_res = a - b;
            4'h6: e_res = a & b;
            4'h7: e_res = a | b;
            4'h8: e_res = ~a;
            4'h9: e_res = a >> 1;
            4'hA: e_res = a << 1;
            4'hB: e_res = p[15:0];
            default: begin e_res = a; e_val = 1'b0; end
        endcase
        e_pos = ($signed(a) > 0);
        checks++;
        if (res !== e_res) begin
            fails++;
            $display("FAIL %s/R12 f=%h a=%h b=%h res actual=%h expected=%h", tag(f), f, a, b, res, e_res);
        end
        checks++;
        if (valid !== e_val) begin
            fails++;
            $display("FAIL R10 f=%h valid actual=%b expected=%b", f, valid, e_val);
        end
        checks++;
        if (pos !== e_pos) begin
            fails++;
            $display("FAIL R11 a=%h pos actual=%b expected=%b", a, pos, e_pos);
        end
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog expired");
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [15:0] grid [7];
        logic [15:0] lf;
        grid[0] = 16'h0000; grid[1] = 16'h0001; grid[2] = 16'h7FFF;
        grid[3] = 16'h8000; grid[4] = 16'hFFFF; grid[5] = 16'h5A5A;
        grid[6] = 16'hA5C3;
        acc = '0; opnd = '0; func = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero inputs, code 0 -> pass-through of 0, not valid (R9, R10, R11)
        apply(16'h0000, 16'h0000, 4'h0);
        // Edge grid over all codes (R1..R11)
        for (int f = 0; f < 16; f++)
            for (int i = 0; i < 7; i++)
                for (int j = 0; j < 7; j++)
                    apply(grid[i], grid[j], 4'(f));
        // R5: operand varied with accumulator held
        for (int j = 0; j < 64; j++)
            apply(16'h3C01, 16'(j * 1031), 4'h8);
        // R8 and dense arithmetic via pseudo-random sweep
        lf = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] b;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            b  = lf ^ 16'(k * 40503);
            apply(lf, b, 4'(k));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule